// File: doc/BRIEF.md
# Byte Divider with Status Flags

This block is the divide step of a small microcontroller datapath. A one-cycle start strobe captures an unsigned 8-bit dividend and an unsigned 8-bit divisor. A restoring shift-subtract engine then works out one quotient bit per clock. At the end the block returns a single 16-bit word, with the quotient in the upper byte and the remainder in the lower byte, plus four status flags: carry (CY), overflow (OV), negative (N) and zero (Z). A one-cycle done pulse marks the end of each operation.

A zero divisor is an exception. The block completes it in one cycle, raises OV, clears CY and forces the result word and the N and Z flags to zero, so its outputs are always predictable. The result and the flags are held in registers. They keep their values until the next operation completes or the block is reset. While the block is busy it ignores further start strobes.

Top module: `bytediv_unit`

## Requirements
- R1: For a nonzero divisor, `result[15:8]` equals the unsigned quotient dividend/divisor and `result[7:0]` equals the unsigned remainder (e.g. 251 by 18 gives quotient 13 and remainder 17).
- R2: For a nonzero divisor, `cy` and `ov` are both 0 when `done` is high.
- R3: For a nonzero divisor, `neg` equals bit 7 of the quotient when `done` is high.
- R4: For a nonzero divisor, `zero` is 1 exactly when the quotient is 00h when `done` is high.
- R5: For a divisor of 00h, `done` shows `ov`=1, `cy`=0, `neg`=0, `zero`=0 and `result`=0000h.
- R6: Count the clock edge that samples `start` high while `busy` is low as edge 0. Then `done` is high for exactly one cycle after edge 8 for a nonzero divisor, or after edge 1 for a zero divisor. `busy` is high from edge 0 until the edge that raises `done`, and is never high together with `done`.
- R7: A `start` strobe while `busy` is high has no effect: the running operation completes on its original schedule with its original operands.
- R8: `result` and the four flags change only on the edge that raises `done` (or on reset). They stay stable in every other cycle, whatever the operand inputs do.
- R9: A synchronous active-high `rst` clears `busy`, `done`, `result` and all four flags on the next edge, and also aborts an operation that is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a divide; operands captured on this edge when idle |
| dividend | input | 8 | Unsigned dividend |
| divisor | input | 8 | Unsigned divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Quotient in [15:8], remainder in [7:0] |
| cy | output | 1 | Carry flag, always cleared by a divide |
| ov | output | 1 | Overflow flag, set on a zero divisor |
| neg | output | 1 | Quotient bit 7 |
| zero | output | 1 | Quotient equals zero |

## Verification
The edge that samples `start` is edge 0. Results and flags for a nonzero divisor are due on edge 8, and for a zero divisor on edge 1. The bench drives inputs and samples outputs on falling edges. It counts falling edges from edge 0 until `done` appears and requires that count to be exactly 8 or 1. It checks `busy` at every falling edge before that, and compares quotient, remainder and all four flags in the `done` cycle. One falling edge later it requires `done` low and the outputs unchanged, with the operand inputs scrambled. Operations with a strobe injected mid-flight must still finish on edge 8 with the first operands.

// File: rtl/bytediv_pkg.sv
package bytediv_pkg;
    parameter int unsigned DW = 8;
    localparam int unsigned RW = 2 * DW;
    localparam int unsigned CW = $clog2(DW);

    typedef logic [DW-1:0] byte_t;

    typedef struct packed {
        byte_t quo;
        byte_t rem;
    } packed_res_t;

    typedef struct packed {
        logic cy;
        logic ov;
        logic n;
        logic z;
    } flags_t;

    typedef struct packed {
        byte_t rem;
        logic  qbit;
    } step_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_ZERO = 2'd2
    } state_e;

    function automatic flags_t make_flags(input byte_t q, input logic dz);
        flags_t f;
        f.cy = 1'b0;
        if (dz) begin
            f.ov = 1'b1;
            f.n  = 1'b0;
            f.z  = 1'b0;
        end else begin
            f.ov = 1'b0;
            f.n  = q[DW-1];
            f.z  = (q == '0);
        end
        return f;
    endfunction
endpackage

// File: rtl/bytediv_step.sv
module bytediv_step
    import bytediv_pkg::*;
(
    input  byte_t rem_in,
    input  logic  next_bit,
    input  byte_t div,
    output step_t step_out
);
    logic [DW:0] trial;
    logic [DW:0] diff;

    always_comb begin
        trial         = {rem_in, next_bit};
        diff          = trial - {1'b0, div};
        step_out.qbit = ~diff[DW];
        step_out.rem  = step_out.qbit ? diff[DW-1:0] : trial[DW-1:0];
    end
endmodule

// File: rtl/bytediv_ctrl.sv
module bytediv_ctrl
    import bytediv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic div_zero,
    output logic load,
    output logic step_en,
    output logic finish,
    output logic busy
);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    state_e        st_q, st_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        load    = (st_q == ST_IDLE) && start;
        step_en = (st_q == ST_RUN);
        finish  = ((st_q == ST_RUN) && (cnt_q == LAST)) || (st_q == ST_ZERO);
        busy    = (st_q != ST_IDLE);
        st_d    = st_q;
        case (st_q)
            ST_IDLE: if (start) st_d = div_zero ? ST_ZERO : ST_RUN;
            ST_RUN:  if (cnt_q == LAST) st_d = ST_IDLE;
            ST_ZERO: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (load)
                cnt_q <= '0;
            else if (step_en)
                cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/bytediv_flags.sv
module bytediv_flags
    import bytediv_pkg::*;
(
    input  byte_t  quo,
    input  logic   dz,
    output flags_t flags
);
    always_comb flags = make_flags(quo, dz);
endmodule

// File: rtl/bytediv_unit.sv
module bytediv_unit
    import bytediv_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [DW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic          busy,
    output logic          done,
    output logic [RW-1:0] result,
    output logic          cy,
    output logic          ov,
    output logic          neg,
    output logic          zero
);
    logic load, step_en, finish;

    byte_t       rem_q, quo_q, div_q;
    step_t       step;
    byte_t       quo_next;
    logic        dz;
    flags_t      flg_next, flg_q;
    packed_res_t res_next, res_q;
    logic        done_q;

    bytediv_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .div_zero (divisor == '0),
        .load     (load),
        .step_en  (step_en),
        .finish   (finish),
        .busy     (busy)
    );

    bytediv_step u_step (
        .rem_in   (rem_q),
        .next_bit (quo_q[DW-1]),
        .div      (div_q),
        .step_out (step)
    );

    always_comb begin
        dz       = (div_q == '0);
        quo_next = {quo_q[DW-2:0], step.qbit};
        if (dz)
            res_next = '0;
        else
            res_next = '{quo: quo_next, rem: step.rem};
    end

    bytediv_flags u_flags (
        .quo   (quo_next),
        .dz    (dz),
        .flags (flg_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            quo_q  <= '0;
            div_q  <= '0;
            res_q  <= '0;
            flg_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
            if (load) begin
                rem_q <= '0;
                quo_q <= dividend;
                div_q <= divisor;
            end else if (step_en) begin
                rem_q <= step.rem;
                quo_q <= quo_next;
            end
            if (finish) begin
                res_q <= res_next;
                flg_q <= flg_next;
            end
        end
    end

    assign done   = done_q;
    assign result = res_q;
    assign cy     = flg_q.cy;
    assign ov     = flg_q.ov;
    assign neg    = flg_q.n;
    assign zero   = flg_q.z;
endmodule

// File: rtl/bytediv_chk.sv
module bytediv_chk
    import bytediv_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [RW-1:0] result,
    input logic          cy,
    input logic          ov,
    input logic          neg,
    input logic          zero
);
    localparam int unsigned EW = $clog2(DW + 3);
    localparam logic [EW-1:0] RUN_EDGES  = EW'(DW + 1);
    localparam logic [EW-1:0] ZERO_EDGES = EW'(2);

    logic [EW-1:0] span_q;

    always_ff @(posedge clk) begin
        if (rst)
            span_q <= '0;
        else if (start && !busy)
            span_q <= EW'(1);
        else if (busy)
            span_q <= span_q + 1'b1;
    end

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_busy_done_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> (ov ? (span_q == ZERO_EDGES) : (span_q == RUN_EDGES)));

    assert_busy_rise_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    assert_cy_clear_R2: assert property (@(posedge clk) disable iff (rst)
        done |-> !cy);

    assert_neg_msb_R3: assert property (@(posedge clk) disable iff (rst)
        (done && !ov) |-> (neg == result[RW-1]));

    assert_zero_quo_R4: assert property (@(posedge clk) disable iff (rst)
        (done && !ov) |-> (zero == (result[RW-1:DW] == '0)));

    assert_div_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (done && ov) |-> (result == '0 && !cy && !neg && !zero));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!done && !$past(rst)) |-> ($stable(result) && $stable({cy, ov, neg, zero})));

    assert_reset_clear_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !done && result == '0 && !cy && !ov && !neg && !zero));
endmodule

bind bytediv_unit bytediv_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .result (result),
    .cy     (cy),
    .ov     (ov),
    .neg    (neg),
    .zero   (zero)
);

// File: tb/sim_bytediv_unit.sv
module sim_bytediv_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  dividend = '0;
    logic [7:0]  divisor = '0;
    logic        busy, done, cy, ov, neg, zero;
    logic [15:0] result;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    bytediv_unit u0 (
        .clk(clk), .rst(rst), .start(start), .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done), .result(result), .cy(cy), .ov(ov), .neg(neg), .zero(zero)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(input logic [7:0] a, input logic [7:0] b);
        if (b == 0) return 16'h0000;
        return {8'(a / b), 8'(a % b)};
    endfunction

    task automatic run_div(input logic [7:0] a, input logic [7:0] b, input bit inject);
        int cycles;
        logic [15:0] ew;
        logic [15:0] held;
        logic [3:0]  hflags;
        ew = exp_word(a, b);
        @(negedge clk);
        start = 1'b1; dividend = a; divisor = b;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R6", "busy after start", int'(busy), 1);
        cycles = 0;
        while (done !== 1'b1 && cycles < 20) begin
            @(negedge clk);
            cycles++;
            if (inject && cycles == 3) begin
                // R7: strobe with other operands while busy
                start = 1'b1; dividend = ~a; divisor = b ^ 8'h5a;
            end
            if (inject && cycles == 4) begin
                start = 1'b0;
            end
            if (done !== 1'b1)
                chk(busy === 1'b1, "R6", "busy while running", int'(busy), 1);
        end
        chk(cycles == ((b == 0) ? 1 : 8), inject ? "R7" : "R6", "done latency", cycles,
            (b == 0) ? 1 : 8);
        chk(busy === 1'b0, "R6", "busy in done cycle", int'(busy), 0);
        if (b != 0) begin
            chk(result === ew, "R1", "result word", int'(result), int'(ew));
            chk(cy === 1'b0 && ov === 1'b0, "R2", "cy/ov", int'({cy, ov}), 0);
            chk(neg === ew[15], "R3", "neg flag", int'(neg), int'(ew[15]));
            chk(zero === (ew[15:8] == 0), "R4", "zero flag", int'(zero),
                int'(ew[15:8] == 0));
        end else begin
            chk(result === 16'h0000 && {cy, ov, neg, zero} === 4'b0100, "R5",
                "div by zero outputs", int'({result, cy, ov, neg, zero}), 4);
        end
        held = result; hflags = {cy, ov, neg, zero};
        dividend = $urandom; divisor = $urandom;
        @(negedge clk);
        chk(done === 1'b0, "R6", "done single pulse", int'(done), 0);
        chk(result === held && {cy, ov, neg, zero} === hflags, "R8", "outputs held",
            int'(result), int'(held));
    endtask

    task automatic check_reset_state(input string what);
        chk(busy === 1'b0 && done === 1'b0, "R9", {what, " busy/done"}, int'({busy, done}), 0);
        chk(result === 16'h0 && {cy, ov, neg, zero} === 4'b0, "R9", {what, " result/flags"},
            int'({result, cy, ov, neg, zero}), 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_reset_state("after reset");

        run_div(8'd251, 8'd18, 1'b0);
        run_div(8'd251, 8'd18, 1'b1);
        run_div(8'd77, 8'd0, 1'b0);
        run_div(8'd0, 8'd0, 1'b0);
        run_div(8'd255, 8'd1, 1'b0);
        run_div(8'd128, 8'd1, 1'b1);
        run_div(8'd5, 8'd7, 1'b0);
        run_div(8'd0, 8'd9, 1'b0);
        run_div(8'd255, 8'd255, 1'b0);
        run_div(8'd200, 8'd255, 1'b0);
        run_div(8'd254, 8'd128, 1'b0);

        // R9: reset in the middle of an operation
        @(negedge clk);
        start = 1'b1; dividend = 8'd250; divisor = 8'd3;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_reset_state("mid-op reset");
        repeat (12) @(negedge clk);
        chk(done === 1'b0 && result === 16'h0, "R9", "aborted op stays silent",
            int'({done, result}), 0);

        for (int i = 0; i < 9000; i++) begin
            logic [7:0] a, b;
            a = 8'($urandom);
            b = (($urandom % 16) == 0) ? 8'd0 : 8'($urandom);
            run_div(a, b, (($urandom % 8) == 0));
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #3900000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule